// File: doc/BRIEF.md
# PCI Configuration Target (Type 0, Single Data Phase)

This block is the target side of the configuration space of a single-function PCI device. It watches the shared bus for the start of a transaction and records the address phase: the AD lines, the command on C/BE#, and the chip-select line that the host bridge raises for this slot. One clock later it checks PAR against the recorded address phase. The cycle is claimed only when every condition holds together: the chip select was high, the command is a configuration read or write, the address is type 0, the function number is the one this device implements, and the address parity is clean.

A claimed cycle asserts DEVSEL# with medium timing. TRDY# follows one clock later for exactly one data phase. If the initiator still holds FRAME#, meaning it wants a burst, STOP# is raised together with TRDY#, so the target transfers one dword and then disconnects. Writes go through a small bank of dword registers and respect the byte enables. Reads drive AD from the clock in which DEVSEL# first asserts, and drive PAR one clock behind AD. Register 0 holds fixed identifier values. Register slots beyond the implemented bank read as zero.

Top module: `cfgt_target`

## Requirements
- R1: While reset is high, and in the first clock after it, DEVSEL#, TRDY# and STOP# are high and neither AD nor PAR is driven.
- R2: The cycle is claimed only if, in the address phase (the first clock with FRAME# low after a clock with FRAME# high), IDSEL is high, C/BE# is 1010 (config read) or 1011 (config write), AD[1:0] is 00 and AD[10:8] is 000. Any other address phase leaves DEVSEL# high, and a write inside such a cycle changes no register.
- R3: PAR sampled in the clock after the address phase must equal the XOR of AD[31:0] and C/BE#[3:0] from the address phase. On a mismatch the cycle is not claimed.
- R4: If the address phase is clock N, DEVSEL# goes low in clock N+2 and TRDY# goes low in clock N+3.
- R5: TRDY# stays low until a clock in which IRDY# is also low. In the clock after that transfer, DEVSEL#, TRDY# and STOP# are all high again.
- R6: STOP# goes low together with TRDY# exactly when FRAME# was low in clock N+2. Otherwise STOP# stays high.
- R7: AD[7:2] selects the dword register. On a read, AD is driven from clock N+2 through the transfer clock with that register's value. Register 0 reads {device ID[31:16], vendor ID[15:0]}. Indices at or beyond the bank size read zero.
- R8: On a write, byte k of the selected register takes AD[8k+7:8k] only if C/BE#[k] is low in the transfer clock. The other bytes keep their old value.
- R9: Writes to register 0 and to indices beyond the bank size have no effect.
- R10: On a read, PAR is driven from the clock after AD is first driven until one clock after the transfer. In each of those clocks it equals the XOR of the AD value driven and C/BE# in the previous clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_n | input | 1 | FRAME#, active low |
| irdy_n | input | 1 | IRDY#, initiator ready, active low |
| idsel | input | 1 | Configuration chip select for this slot |
| ad_in | input | 32 | Sampled AD bus |
| cbe_n | input | 4 | Sampled C/BE# bus |
| par_in | input | 1 | Sampled PAR |
| ad_out | output | 32 | Read data for AD |
| ad_oe | output | 1 | AD output enable |
| par_out | output | 1 | PAR value when driven |
| par_oe | output | 1 | PAR output enable |
| devsel_n | output | 1 | DEVSEL#, active low |
| trdy_n | output | 1 | TRDY#, active low |
| stop_n | output | 1 | STOP#, active low |

## Verification
The assertions assume a well-behaved initiator. It holds FRAME# low for one address clock, or keeps it low until the transfer when it wants a burst. It leaves at least one clock with FRAME# high between transactions. It keeps AD and C/BE# stable while TRDY# waits for IRDY#. The bench drives only transactions of that shape. It varies chip select, command, type bits, function number, parity, byte enables, burst intent and IRDY# wait states. It releases FRAME# in the turnaround clock, so the properties that key on falling DEVSEL#, TRDY# and STOP# always see the protocol they expect.

// File: rtl/cfgt_pkg.sv
package cfgt_pkg;

    localparam logic [3:0] CMD_CFG_RD = 4'b1010;
    localparam logic [3:0] CMD_CFG_WR = 4'b1011;

    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for an address phase
        ST_ACHK,   // parity clock: decide the claim
        ST_WAIT,   // DEVSEL# low, TRDY# not yet
        ST_XFER,   // TRDY# low until IRDY#
        ST_TURN    // release, trailing PAR for reads
    } cfg_state_t;

    typedef struct packed {
        logic [31:0] ad;
        logic [3:0]  cbe_n;
        logic        idsel;
    } addr_phase_t;

    function automatic logic even_par(input logic [31:0] ad, input logic [3:0] cbe);
        return ^{ad, cbe};
    endfunction

    function automatic logic [31:0] merge_bytes(input logic [31:0] old_w,
                                                input logic [31:0] new_w,
                                                input logic [3:0]  lane_en);
        logic [31:0] r;
        for (int k = 0; k < 4; k++)
            r[8*k +: 8] = lane_en[k] ? new_w[8*k +: 8] : old_w[8*k +: 8];
        return r;
    endfunction

endpackage

// File: rtl/cfgt_claim.sv
module cfgt_claim
    import cfgt_pkg::*;
#(
    parameter logic [2:0] FUNC_NUM = 3'd0
) (
    input  addr_phase_t ap,
    input  logic        par_in,
    output logic        hit,
    output logic        is_write
);
    logic cmd_ok;
    logic type0;
    logic func_ok;
    logic par_ok;

    always_comb begin
        cmd_ok   = (ap.cbe_n == CMD_CFG_RD) || (ap.cbe_n == CMD_CFG_WR);
        type0    = (ap.ad[1:0] == 2'b00);
        func_ok  = (ap.ad[10:8] == FUNC_NUM);
        par_ok   = (par_in == even_par(ap.ad, ap.cbe_n));
        is_write = (ap.cbe_n == CMD_CFG_WR);
        hit      = ap.idsel && cmd_ok && type0 && func_ok && par_ok;
    end
endmodule

// File: rtl/cfgt_regfile.sv
module cfgt_regfile
    import cfgt_pkg::*;
#(
    parameter int          NREGS     = 16,
    parameter logic [15:0] VENDOR_ID = 16'hA5C3,
    parameter logic [15:0] DEVICE_ID = 16'h7E21
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [5:0]  idx,
    input  logic        we,
    input  logic [3:0]  lane_en,
    input  logic [31:0] wdata,
    output logic [31:0] rdata
);
    localparam int IW = (NREGS > 1) ? $clog2(NREGS) : 1;

    logic [NREGS-1:0][31:0] words;

    for (genvar i = 0; i < NREGS; i++) begin : g_word
        if (i == 0) begin : g_id
            assign words[i] = {DEVICE_ID, VENDOR_ID};
        end else begin : g_rw
            logic [31:0] q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else if (we && idx == 6'(i))
                    q <= merge_bytes(q, wdata, lane_en);
            end
            assign words[i] = q;
        end
    end

    always_comb begin
        if (32'(idx) < NREGS)
            rdata = words[idx[IW-1:0]];
        else
            rdata = '0;
    end
endmodule

// File: rtl/cfgt_target.sv
module cfgt_target
    import cfgt_pkg::*;
#(
    parameter int          NREGS     = 16,
    parameter logic [15:0] VENDOR_ID = 16'hA5C3,
    parameter logic [15:0] DEVICE_ID = 16'h7E21,
    parameter logic [2:0]  FUNC_NUM  = 3'd0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        frame_n,
    input  logic        irdy_n,
    input  logic        idsel,
    input  logic [31:0] ad_in,
    input  logic [3:0]  cbe_n,
    input  logic        par_in,
    output logic [31:0] ad_out,
    output logic        ad_oe,
    output logic        par_out,
    output logic        par_oe,
    output logic        devsel_n,
    output logic        trdy_n,
    output logic        stop_n
);
    cfg_state_t  st;
    addr_phase_t ap_q;
    logic        frame_q;
    logic        wr_q;
    logic        stop_q;
    logic        par_q;
    logic        hit;
    logic        hit_wr;
    logic        start;
    logic        wr_en;
    logic [31:0] rdata;

    assign start = (st == ST_IDLE) && !frame_n && frame_q;

    cfgt_claim #(.FUNC_NUM(FUNC_NUM)) u_claim (
        .ap       (ap_q),
        .par_in   (par_in),
        .hit      (hit),
        .is_write (hit_wr)
    );

    assign wr_en = (st == ST_XFER) && !irdy_n && wr_q;

    cfgt_regfile #(
        .NREGS     (NREGS),
        .VENDOR_ID (VENDOR_ID),
        .DEVICE_ID (DEVICE_ID)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .idx     (ap_q.ad[7:2]),
        .we      (wr_en),
        .lane_en (~cbe_n),
        .wdata   (ad_in),
        .rdata   (rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            ap_q    <= '0;
            frame_q <= 1'b1;
            wr_q    <= 1'b0;
            stop_q  <= 1'b0;
            par_q   <= 1'b0;
        end else begin
            frame_q <= frame_n;
            par_q   <= even_par(ad_out, cbe_n);
            case (st)
                ST_IDLE: if (start) begin
                    ap_q <= '{ad: ad_in, cbe_n: cbe_n, idsel: idsel};
                    st   <= ST_ACHK;
                end
                ST_ACHK: if (hit) begin
                    wr_q <= hit_wr;
                    st   <= ST_WAIT;
                end else begin
                    st   <= ST_IDLE;
                end
                ST_WAIT: begin
                    stop_q <= !frame_n;
                    st     <= ST_XFER;
                end
                ST_XFER: if (!irdy_n) st <= ST_TURN;
                ST_TURN: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        devsel_n = !((st == ST_WAIT) || (st == ST_XFER));
        trdy_n   = !(st == ST_XFER);
        stop_n   = !((st == ST_XFER) && stop_q);
        ad_oe    = !wr_q && ((st == ST_WAIT) || (st == ST_XFER));
        par_oe   = !wr_q && ((st == ST_XFER) || (st == ST_TURN));
        ad_out   = rdata;
        par_out  = par_q;
    end

    // R2: a claim only follows an address phase that carried IDSEL
    a_r2_claim_has_idsel: assert property (@(posedge clk) disable iff (rst)
        $fell(devsel_n) |-> ap_q.idsel);

    // R4: TRDY# drops only after a clock of DEVSEL# alone
    a_r4_devsel_leads_trdy: assert property (@(posedge clk) disable iff (rst)
        $fell(trdy_n) |-> ($past(!devsel_n) && $past(trdy_n)));

    // R5: one data phase, then everything released
    a_r5_single_phase: assert property (@(posedge clk) disable iff (rst)
        (!trdy_n && !irdy_n) |=> (devsel_n && trdy_n && stop_n));

    // R6: disconnect only when the initiator kept FRAME# low
    a_r6_stop_on_frame: assert property (@(posedge clk) disable iff (rst)
        $fell(stop_n) |-> $past(!frame_n));

    // R10: PAR enable trails AD enable by a clock
    a_r10_par_after_ad: assert property (@(posedge clk) disable iff (rst)
        $rose(par_oe) |-> $past(ad_oe));
endmodule

// File: tb/cfgt_target_test.sv
`timescale 1ns/1ps
module cfgt_target_test;
    localparam int          NREGS = 16;
    localparam logic [15:0] VID   = 16'hA5C3;
    localparam logic [15:0] DID   = 16'h7E21;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_n = 1'b1;
    logic        irdy_n = 1'b1;
    logic        idsel = 1'b0;
    logic [31:0] ad_in = '0;
    logic [3:0]  cbe_n = 4'hF;
    logic        par_in = 1'b0;
    logic [31:0] ad_out;
    logic        ad_oe, par_out, par_oe, devsel_n, trdy_n, stop_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] mregs [64];

    always #5 clk = ~clk;

    cfgt_target #(.NREGS(NREGS), .VENDOR_ID(VID), .DEVICE_ID(DID)) uut (
        .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .idsel(idsel),
        .ad_in(ad_in), .cbe_n(cbe_n), .par_in(par_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .par_out(par_out), .par_oe(par_oe), .devsel_n(devsel_n), .trdy_n(trdy_n),
        .stop_n(stop_n)
    );

    task automatic cmp(string rq, bit edev, bit etrdy, bit estop, bit eadoe, bit eparoe,
                       logic [31:0] ead, bit epar);
        bit ok;
        @(negedge clk);
        checks++;
        ok = (devsel_n === edev) && (trdy_n === etrdy) && (stop_n === estop) &&
             (ad_oe === eadoe) && (par_oe === eparoe) &&
             (!eadoe || ad_out === ead) && (!eparoe || par_out === epar);
        if (!ok) begin
            errors++;
            $display("FAIL %s t=%0t got dev=%b trdy=%b stop=%b adoe=%b paroe=%b ad=%h par=%b exp dev=%b trdy=%b stop=%b adoe=%b paroe=%b ad=%h par=%b",
                     rq, $time, devsel_n, trdy_n, stop_n, ad_oe, par_oe, ad_out, par_out,
                     edev, etrdy, estop, eadoe, eparoe, ead, epar);
        end
    endtask

    task automatic next_cycle();
        @(posedge clk);
        #1;
    endtask

    task automatic model_wr(int idx, logic [3:0] be, logic [31:0] wd);
        if (idx > 0 && idx < NREGS)
            for (int k = 0; k < 4; k++)
                if (be[k]) mregs[idx][8*k +: 8] = wd[8*k +: 8];
    endtask

    // One configuration transaction with a cycle-by-cycle expectation.
    task automatic xact(string rq, bit sel, logic [3:0] cmd, logic [31:0] addr,
                        logic [3:0] be, logic [31:0] wd, bit hold, int waits, bit badp);
        bit claim = sel && (cmd == 4'b1010 || cmd == 4'b1011) && addr[1:0] == 2'b00 &&
                    addr[10:8] == 3'b000 && !badp;
        bit rd = (cmd == 4'b1010);
        int idx = int'(addr[7:2]);
        logic [31:0] exp = mregs[idx];
        bit ep = ^{exp, ~be};
        // address phase
        next_cycle();
        frame_n = 1'b0; irdy_n = 1'b1; idsel = sel; ad_in = addr; cbe_n = cmd;
        cmp(rq, 1, 1, 1, 0, 0, '0, 0);
        // parity clock, data presented
        next_cycle();
        par_in = (^{addr, cmd}) ^ badp;
        frame_n = !hold; irdy_n = (waits > 0); idsel = 1'b0; ad_in = wd; cbe_n = ~be;
        cmp(rq, 1, 1, 1, 0, 0, '0, 0);
        if (!claim) begin
            for (int c = 0; c < 4; c++) begin
                next_cycle();
                frame_n = 1'b1; irdy_n = 1'b1;
                cmp(rq, 1, 1, 1, 0, 0, '0, 0);
            end
            return;
        end
        // DEVSEL# only (R4, R7)
        next_cycle();
        cmp(rq, 0, 1, 1, rd, 0, exp, 0);
        // TRDY# clocks (R5, R6, R10)
        for (int w = 0; w <= waits; w++) begin
            next_cycle();
            if (w == waits) irdy_n = 1'b0;
            cmp(rq, 0, 0, !hold, rd, rd, exp, ep);
        end
        // turnaround
        next_cycle();
        frame_n = 1'b1; irdy_n = 1'b1;
        cmp(rq, 1, 1, 1, 0, rd, '0, ep);
        if (!rd) model_wr(idx, be, wd);
        next_cycle();
        cmp(rq, 1, 1, 1, 0, 0, '0, 0);
    endtask

    task automatic rd_reg(string rq, int idx);
        xact(rq, 1, 4'b1010, 32'(idx) << 2, 4'hF, 32'h0, 0, 0, 0);
    endtask

    task automatic wr_reg(string rq, int idx, logic [3:0] be, logic [31:0] wd);
        xact(rq, 1, 4'b1011, 32'(idx) << 2, be, wd, 0, 0, 0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mregs[i] = '0;
        mregs[0] = {DID, VID};
        // R1: reset state
        cmp("R1", 1, 1, 1, 0, 0, '0, 0);
        repeat (2) cmp("R1", 1, 1, 1, 0, 0, '0, 0);
        next_cycle();
        rst = 1'b0;
        cmp("R1", 1, 1, 1, 0, 0, '0, 0);

        // R7 / R4 / R10: identifier read
        rd_reg("R7_id", 0);
        // R8: full and partial byte-enable writes
        wr_reg("R8_full", 2, 4'hF, 32'hDEADBEEF);
        rd_reg("R8_full_rb", 2);
        wr_reg("R8_lanes", 2, 4'b0101, 32'h11223344);
        rd_reg("R8_lanes_rb", 2);
        wr_reg("R8_none", 2, 4'b0000, 32'hFFFFFFFF);
        rd_reg("R8_none_rb", 2);
        wr_reg("R8_top", 15, 4'b1000, 32'hC0000000);
        rd_reg("R8_top_rb", 15);
        // R9: read-only and unimplemented
        wr_reg("R9_id", 0, 4'hF, 32'h0);
        rd_reg("R9_id_rb", 0);
        wr_reg("R9_unimp", 40, 4'hF, 32'h12345678);
        rd_reg("R9_unimp_rb", 40);
        rd_reg("R7_unimp", 63);
        // R2: every claim condition missing in turn, with writes that must not land
        xact("R2_noidsel", 0, 4'b1011, 32'h8, 4'hF, 32'hAAAAAAAA, 0, 0, 0);
        xact("R2_memcmd", 1, 4'b0110, 32'h8, 4'hF, 32'h0, 0, 0, 0);
        xact("R2_type1", 1, 4'b1011, 32'h9, 4'hF, 32'hBBBBBBBB, 0, 0, 0);
        xact("R2_func1", 1, 4'b1011, 32'h108, 4'hF, 32'hCCCCCCCC, 0, 0, 0);
        rd_reg("R2_unchanged", 2);
        // R3: bad address parity on read and write
        xact("R3_badpar_rd", 1, 4'b1010, 32'h0, 4'hF, 32'h0, 0, 0, 1);
        xact("R3_badpar_wr", 1, 4'b1011, 32'h8, 4'hF, 32'hDDDDDDDD, 0, 0, 1);
        rd_reg("R3_unchanged", 2);
        // R6: burst intent gives disconnect
        xact("R6_stop_wr", 1, 4'b1011, 32'h0C, 4'hF, 32'h0F0F0F0F, 1, 0, 0);
        xact("R6_stop_rd", 1, 4'b1010, 32'h0C, 4'hF, 32'h0, 1, 1, 0);
        // R5: wait states on IRDY#
        xact("R5_wait_rd", 1, 4'b1010, 32'h08, 4'b0011, 32'h0, 0, 2, 0);
        xact("R5_wait_wr", 1, 4'b1011, 32'h14, 4'b1100, 32'h89ABCDEF, 0, 3, 0);
        rd_reg("R5_wait_rb", 5);
        // R10: read parity with partial enables and wide data
        xact("R10_par", 1, 4'b1010, 32'h3C, 4'b0110, 32'h0, 0, 0, 0);

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule